// File: doc/BRIEF.md
# Elliptic-Curve Engine Register and Interrupt Controller

This block is the 32-bit memory-mapped front end of an elliptic-curve arithmetic engine. Software reaches it through a simple register bus made of an address, a write enable, write data and combinational read data. The block holds an initial-setting word that drives the engine's synchronous reset and clock enable. It also holds a control word that carries the mode, the function select, the option bits, the interrupt masks and the operand swap controls. An interrupt status word pulses start and hash-ready to the engine and latches the engine's per-mode completion events and its decode-failure event.

There are eight operand banks of eight 32-bit words each. Four are inputs that software fills and the engine reads. Four are outputs that the engine loads in one cycle. Each bank has its own pair of swap controls. One reverses the byte order inside every word. The other reverses the order of the eight words. For input banks the swap applies on the path to the engine. For output banks it applies on the bus read path. A single level-sensitive interrupt line goes high for any latched event whose mask bit is clear.

Top module: `ecc_ctrl_regs`

## Requirements
- R1: After reset, the registers at 0x000, 0x008 and 0x00C read 0, and `irq`, `engStart`, `engHashOk`, `engSyncRst` and `engClkEn` are 0.
- R2: At 0x000, bit 0 drives `engSyncRst` and bit 8 drives `engClkEn`. All other bits of that word read back as 0.
- R3: Writing 1 to bit 0 or bit 2 of 0x008 raises `engStart` or `engHashOk` respectively. The pulse lasts exactly one cycle and starts at the clock edge that takes the write. Both bits read back as 0.
- R4: Bit 4 of 0x008 reads the live `engBusy` input. Bus writes to that bit have no effect.
- R5: A pulse on `engDone[m]` sets bit 8+m of 0x008, and a pulse on `engDecodeFail` sets bit 12. A set bit stays set while 0 is written to it and clears when 1 is written to it.
- R6: When an engine event and a write-1-to-clear of the same bit happen in the same cycle, the bit stays set.
- R7: `irq` is high while any status bit in 0x008 bits 12:8 is set and its mask in 0x00C is 0. Bit 11 masks decode-fail, and bits 12 to 15 mask mode 0 to mode 3.
- R8: 0x00C reads back all 32 bits as written. `engMode` is bits 1:0, `engFunc` is bits 3:2 and `engOpt` is bits 10:4.
- R9: Input banks X1, Y1, X2 and Y2 are at 0x010, 0x030, 0x050 and 0x070. Word i of a bank sits at base+4i and maps to operand bits 32i+31:32i. Bank k (0 to 3) is sent to the engine byte-swapped when 0x00C bit 16+2k is set and word-swapped when bit 17+2k is set. Byte swap reverses the bytes within each word. Word swap maps word i to word 7-i.
- R10: Output banks XO1, YO1, XO2 and YO2 are at 0x090, 0x0B0, 0x0D0 and 0x0F0, and are all loaded from `engRes*` in the cycle `engResultValid` is high. A bus read of output bank j (0 to 3) applies byte swap when 0x00C bit 24+2j is set and word swap when bit 25+2j is set.
- R11: The YO2 bank (0x0F0 to 0x10C) ignores bus writes. The other three output banks accept bus writes.
- R12: 0x200 reads `engDebug`. Unmapped addresses and addresses with nonzero bits 1:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | ADDR_W | Byte address |
| regWe | input | 1 | Write enable |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational |
| engClkEn | output | 1 | Engine clock enable |
| engSyncRst | output | 1 | Engine synchronous reset |
| engStart | output | 1 | Start pulse |
| engHashOk | output | 1 | Hash-ready pulse |
| engMode | output | 2 | Mode select |
| engFunc | output | 2 | Function select |
| engOpt | output | 7 | Option bits (add-point through decode enable) |
| engOpX1 | output | 256 | Swapped X1 operand |
| engOpY1 | output | 256 | Swapped Y1 operand |
| engOpX2 | output | 256 | Swapped X2 operand |
| engOpY2 | output | 256 | Swapped Y2 operand |
| engBusy | input | 1 | Engine busy |
| engDone | input | 4 | Per-mode completion pulses |
| engDecodeFail | input | 1 | Decode failure pulse |
| engResultValid | input | 1 | Load all output banks |
| engResX1 | input | 256 | Result for XO1 |
| engResY1 | input | 256 | Result for YO1 |
| engResX2 | input | 256 | Result for XO2 |
| engResY2 | input | 256 | Result for YO2 |
| engDebug | input | 32 | Engine debug word |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest case to reach from the ports is an engine completion that lands in the same clock edge as a software clear of the same status bit. The stimulus reaches it by setting the completion input and a bus write of that bit's one-hot value on the same falling edge, so that both are sampled together. The bench then reads the bit back and expects it to be set. Swap behaviour is reached by filling a bank with distinct per-byte patterns and stepping through all four swap-bit combinations. Each result is compared with a reference reordering that the bench computes itself.

// File: rtl/ecc_regs_pkg.sv
package ecc_regs_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_WORDS = 8;
  localparam int NUM_BANKS = 8;
  localparam int NUM_IN    = 4;
  localparam int OP_W      = DATA_W * NUM_WORDS;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int WSEL_W    = $clog2(NUM_WORDS);
  localparam int RO_BANK   = NUM_BANKS - 1;
  localparam int SWAP_BASE = 16;
  localparam int NUM_FLAGS = 5;

  typedef enum logic [2:0] {
    RD_NONE, RD_INIT, RD_IRQ, RD_CTRL, RD_BANK, RD_DBG
  } rdSel_e;

  typedef struct packed {
    logic               wrInit;
    logic               wrIrq;
    logic               wrCtrl;
    logic               wrBank;
    logic [BANK_W-1:0]  bank;
    logic [WSEL_W-1:0]  word;
    rdSel_e             rdSel;
  } regStrobe_t;

  function automatic logic [OP_W-1:0] swapOperand(input logic [OP_W-1:0] op,
                                                  input logic byteSw,
                                                  input logic wordSw);
    logic [OP_W-1:0] res;
    logic [DATA_W-1:0] src;
    for (int i = 0; i < NUM_WORDS; i++) begin
      src = wordSw ? op[(NUM_WORDS-1-i)*DATA_W +: DATA_W] : op[i*DATA_W +: DATA_W];
      for (int b = 0; b < DATA_W/8; b++) begin
        res[i*DATA_W + b*8 +: 8] = byteSw ? src[(DATA_W/8-1-b)*8 +: 8] : src[b*8 +: 8];
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/ecc_reg_decode.sv
module ecc_reg_decode
  import ecc_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output regStrobe_t        strobe
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] IDX_INIT = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_IRQ  = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_BLO  = IDX_W'(4);
  localparam logic [IDX_W-1:0] IDX_BHI  = IDX_W'(4 + NUM_BANKS*NUM_WORDS);
  localparam logic [IDX_W-1:0] IDX_DBG  = IDX_W'('h200 >> 2);

  logic [IDX_W-1:0] idx;
  logic aligned;
  logic [BANK_W+WSEL_W-1:0] rel;

  assign idx     = regAddr[ADDR_W-1:2];
  assign aligned = (regAddr[1:0] == 2'b00);
  assign rel     = (BANK_W+WSEL_W)'(idx - IDX_BLO);

  always_comb begin
    strobe = '0;
    strobe.rdSel = RD_NONE;
    strobe.bank  = rel[WSEL_W +: BANK_W];
    strobe.word  = rel[WSEL_W-1:0];
    if (aligned) begin
      if (idx == IDX_INIT) begin
        strobe.rdSel  = RD_INIT;
        strobe.wrInit = regWe;
      end else if (idx == IDX_IRQ) begin
        strobe.rdSel = RD_IRQ;
        strobe.wrIrq = regWe;
      end else if (idx == IDX_CTRL) begin
        strobe.rdSel  = RD_CTRL;
        strobe.wrCtrl = regWe;
      end else if (idx >= IDX_BLO && idx < IDX_BHI) begin
        strobe.rdSel  = RD_BANK;
        strobe.wrBank = regWe && (rel[WSEL_W +: BANK_W] != BANK_W'(RO_BANK));
      end else if (idx == IDX_DBG) begin
        strobe.rdSel = RD_DBG;
      end
    end
  end
endmodule

// File: rtl/ecc_reg_datapath.sv
module ecc_reg_datapath
  import ecc_regs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strobe,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  output logic                 engClkEn,
  output logic                 engSyncRst,
  output logic                 engStart,
  output logic                 engHashOk,
  output logic [DATA_W-1:0]    ctrlWord,
  output logic [OP_W-1:0]      engOp   [NUM_IN],
  input  logic                 engBusy,
  input  logic [3:0]           engDone,
  input  logic                 engDecodeFail,
  input  logic                 engResultValid,
  input  logic [OP_W-1:0]      engRes  [NUM_BANKS-NUM_IN],
  input  logic [DATA_W-1:0]    engDebug,
  output logic                 irq
);
  logic [1:0]             initQ;
  logic [DATA_W-1:0]      ctrlQ;
  logic [NUM_FLAGS-1:0]   flagQ, setVec, clrVec, maskVec;
  logic                   startQ, hashQ;
  logic [DATA_W-1:0]      bankQ   [NUM_BANKS][NUM_WORDS];
  logic [OP_W-1:0]        rawOp   [NUM_BANKS];
  logic [OP_W-1:0]        viewOp  [NUM_BANKS];
  logic [OP_W-1:0]        selOp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initQ  <= '0;
      ctrlQ  <= '0;
      startQ <= 1'b0;
      hashQ  <= 1'b0;
      flagQ  <= '0;
    end else begin
      if (strobe.wrInit) initQ <= {regWdata[8], regWdata[0]};
      if (strobe.wrCtrl) ctrlQ <= regWdata;
      startQ <= strobe.wrIrq && regWdata[0];
      hashQ  <= strobe.wrIrq && regWdata[2];
      flagQ  <= (flagQ & ~clrVec) | setVec;
    end
  end

  assign setVec  = {engDecodeFail, engDone};
  assign clrVec  = strobe.wrIrq ? regWdata[12:8] : '0;
  assign maskVec = {ctrlQ[11], ctrlQ[15:12]};
  assign irq     = |(flagQ & ~maskVec);

  assign engSyncRst = initQ[0];
  assign engClkEn   = initQ[1];
  assign engStart   = startQ;
  assign engHashOk  = hashQ;
  assign ctrlWord   = ctrlQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BANKS; b++)
        for (int w = 0; w < NUM_WORDS; w++)
          bankQ[b][w] <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (b >= NUM_IN && engResultValid) begin
          for (int w = 0; w < NUM_WORDS; w++)
            bankQ[b][w] <= engRes[b-NUM_IN][w*DATA_W +: DATA_W];
        end else if (strobe.wrBank && int'(strobe.bank) == b) begin
          bankQ[b][strobe.word] <= regWdata;
        end
      end
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      assign rawOp[b][w*DATA_W +: DATA_W] = bankQ[b][w];
    end
    assign viewOp[b] = swapOperand(rawOp[b], ctrlQ[SWAP_BASE+2*b], ctrlQ[SWAP_BASE+2*b+1]);
    if (b < NUM_IN) begin : g_in
      assign engOp[b] = viewOp[b];
    end
  end

  assign selOp = (int'(strobe.bank) < NUM_IN) ? rawOp[strobe.bank] : viewOp[strobe.bank];

  always_comb begin
    case (strobe.rdSel)
      RD_INIT: regRdata = {23'b0, initQ[1], 7'b0, initQ[0]};
      RD_IRQ:  regRdata = {19'b0, flagQ, 3'b0, engBusy, 4'b0};
      RD_CTRL: regRdata = ctrlQ;
      RD_BANK: regRdata = selOp[int'(strobe.word)*DATA_W +: DATA_W];
      RD_DBG:  regRdata = engDebug;
      default: regRdata = '0;
    endcase
  end

  // R3: a start pulse is always caused by a write to the status word one edge before
  a_r3_start_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> $past(strobe.wrIrq));

  // R2: the initial-setting outputs only move after a write to that word
  a_r2_init_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrInit |=> $stable(initQ));

  // R7: the interrupt line needs a latched event
  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flagQ != '0));

  // R11: the read-only output bank changes only on an engine load
  a_r11_ro_bank_hold: assert property (@(posedge clk) disable iff (!rstN)
    !engResultValid |=> $stable(rawOp[RO_BANK]));

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag_chk
    // R6: an engine event wins over a same-cycle clear
    a_r6_event_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
      setVec[f] |=> flagQ[f]);
  end
endmodule

// File: rtl/ecc_ctrl_regs.sv
module ecc_ctrl_regs
  import ecc_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              engClkEn,
  output logic              engSyncRst,
  output logic              engStart,
  output logic              engHashOk,
  output logic [1:0]        engMode,
  output logic [1:0]        engFunc,
  output logic [6:0]        engOpt,
  output logic [255:0]      engOpX1,
  output logic [255:0]      engOpY1,
  output logic [255:0]      engOpX2,
  output logic [255:0]      engOpY2,
  input  logic              engBusy,
  input  logic [3:0]        engDone,
  input  logic              engDecodeFail,
  input  logic              engResultValid,
  input  logic [255:0]      engResX1,
  input  logic [255:0]      engResY1,
  input  logic [255:0]      engResX2,
  input  logic [255:0]      engResY2,
  input  logic [31:0]       engDebug,
  output logic              irq
);
  regStrobe_t        strobe;
  logic [DATA_W-1:0] ctrlWord;
  logic [OP_W-1:0]   opArr  [NUM_IN];
  logic [OP_W-1:0]   resArr [NUM_BANKS-NUM_IN];

  assign resArr[0] = engResX1;
  assign resArr[1] = engResY1;
  assign resArr[2] = engResX2;
  assign resArr[3] = engResY2;
  assign engOpX1   = opArr[0];
  assign engOpY1   = opArr[1];
  assign engOpX2   = opArr[2];
  assign engOpY2   = opArr[3];
  assign engMode   = ctrlWord[1:0];
  assign engFunc   = ctrlWord[3:2];
  assign engOpt    = ctrlWord[10:4];

  ecc_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .regAddr (regAddr),
    .regWe   (regWe),
    .strobe  (strobe)
  );

  ecc_reg_datapath u_datapath (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .regWdata       (regWdata),
    .regRdata       (regRdata),
    .engClkEn       (engClkEn),
    .engSyncRst     (engSyncRst),
    .engStart       (engStart),
    .engHashOk      (engHashOk),
    .ctrlWord       (ctrlWord),
    .engOp          (opArr),
    .engBusy        (engBusy),
    .engDone        (engDone),
    .engDecodeFail  (engDecodeFail),
    .engResultValid (engResultValid),
    .engRes         (resArr),
    .engDebug       (engDebug),
    .irq            (irq)
  );
endmodule

// File: tb/ecc_ctrl_regs_tb.sv
module ecc_ctrl_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0;
  logic [11:0] regAddr = '0;
  logic regWe = 0;
  logic [31:0] regWdata = '0, regRdata;
  logic engClkEn, engSyncRst, engStart, engHashOk, irq;
  logic [1:0] engMode, engFunc;
  logic [6:0] engOpt;
  logic [255:0] engOpX1, engOpY1, engOpX2, engOpY2;
  logic engBusy = 0, engDecodeFail = 0, engResultValid = 0;
  logic [3:0] engDone = '0;
  logic [255:0] engResX1 = '0, engResY1 = '0, engResX2 = '0, engResY2 = '0;
  logic [31:0] engDebug = '0;

  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_ctrl_regs u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .engClkEn(engClkEn), .engSyncRst(engSyncRst),
    .engStart(engStart), .engHashOk(engHashOk), .engMode(engMode), .engFunc(engFunc),
    .engOpt(engOpt), .engOpX1(engOpX1), .engOpY1(engOpY1), .engOpX2(engOpX2),
    .engOpY2(engOpY2), .engBusy(engBusy), .engDone(engDone),
    .engDecodeFail(engDecodeFail), .engResultValid(engResultValid),
    .engResX1(engResX1), .engResY1(engResY1), .engResX2(engResX2),
    .engResY2(engResY2), .engDebug(engDebug), .irq(irq)
  );

  function automatic logic [255:0] refSwap(input logic [255:0] v, input logic bs, input logic ws);
    logic [255:0] r;
    for (int i = 0; i < 8; i++) begin
      int src = ws ? 7 - i : i;
      for (int b = 0; b < 4; b++) begin
        int sb = bs ? 3 - b : b;
        r[i*32 + b*8 +: 8] = v[src*32 + sb*8 +: 8];
      end
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWe = 1; regWdata = d;
    @(posedge clk); #1;
    regWe = 0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    busRead(12'h000, d); chk("R1 init", d, 0);
    busRead(12'h008, d); chk("R1 status", d, 0);
    busRead(12'h00C, d); chk("R1 ctrl", d, 0);
    chk("R1 outs", {irq, engStart, engHashOk, engSyncRst, engClkEn}, 0);
  endtask

  task automatic t_init();
    logic [31:0] d;
    busWrite(12'h000, 32'hFFFF_FFFF);
    chk("R2 rst+clken", {engSyncRst, engClkEn}, 2'b11);
    busRead(12'h000, d); chk("R2 readback", d, 32'h0000_0101);
    busWrite(12'h000, 32'h0000_0100);
    chk("R2 rst only cleared", {engSyncRst, engClkEn}, 2'b01);
  endtask

  task automatic t_pulses();
    logic [31:0] d;
    busWrite(12'h008, 32'h5);
    chk("R3 pulse high", {engStart, engHashOk}, 2'b11);
    @(posedge clk); #1;
    chk("R3 pulse one cycle", {engStart, engHashOk}, 2'b00);
    busRead(12'h008, d); chk("R3 self clear", d & 32'h5, 0);
  endtask

  task automatic t_busy();
    logic [31:0] d;
    engBusy = 1;
    busRead(12'h008, d); chk("R4 busy high", d, 32'h10);
    engBusy = 0;
    busWrite(12'h008, 32'h10);
    busRead(12'h008, d); chk("R4 write ignored", d, 0);
  endtask

  task automatic evPulse(input logic [3:0] dn, input logic df);
    @(negedge clk); engDone = dn; engDecodeFail = df;
    @(posedge clk); #1; engDone = '0; engDecodeFail = 0;
  endtask

  task automatic t_flags();
    logic [31:0] d;
    evPulse(4'b0100, 0);
    busRead(12'h008, d); chk("R5 mode2 set", d, 32'h400);
    chk("R7 irq unmasked", irq, 1);
    busWrite(12'h008, 32'h0);
    busRead(12'h008, d); chk("R5 write0 keeps", d, 32'h400);
    busWrite(12'h008, 32'h400);
    busRead(12'h008, d); chk("R5 w1c", d, 0);
    chk("R7 irq low", irq, 0);
    evPulse(4'b0000, 1);
    busRead(12'h008, d); chk("R5 decode fail", d, 32'h1000);
    busWrite(12'h00C, 32'h800);
    chk("R7 fail masked", irq, 0);
    busWrite(12'h00C, 32'h0);
    chk("R7 fail unmasked", irq, 1);
    busWrite(12'h008, 32'h1000);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    evPulse(4'b0010, 0);
    @(negedge clk);
    regAddr = 12'h008; regWe = 1; regWdata = 32'h200; engDone = 4'b0010;
    @(posedge clk); #1;
    regWe = 0; engDone = '0;
    busRead(12'h008, d); chk("R6 event beats clear", d, 32'h200);
    busWrite(12'h00C, 32'h2000);
    chk("R7 mode1 masked", irq, 0);
    busWrite(12'h00C, 32'h4000);
    chk("R7 other mask", irq, 1);
    busWrite(12'h008, 32'h200);
    busWrite(12'h00C, 32'h0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    busWrite(12'h00C, 32'hA5A5_07F6);
    busRead(12'h00C, d); chk("R8 readback", d, 32'hA5A5_07F6);
    chk("R8 fields", {engMode, engFunc, engOpt}, {2'b10, 2'b01, 7'h7F});
    busWrite(12'h00C, 32'h0);
  endtask

  task automatic t_inbank();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) begin
      v[i*32 +: 32] = 32'h1020_3040 + 32'(i) * 32'h0101_0101;
      busWrite(12'h050 + 12'(4*i), v[i*32 +: 32]);
    end
    for (int m = 0; m < 4; m++) begin
      busWrite(12'h00C, 32'(m) << 20);
      chk("R9 X2 operand swap", engOpX2, refSwap(v, m[0], m[1]));
    end
    chk("R9 X1 untouched", engOpX1, 0);
    busWrite(12'h00C, 32'h0);
  endtask

  task automatic t_outbank();
    logic [31:0] d;
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = 32'hC0DE_0000 + 32'(i * 17);
    engResY1 = v; engResY2 = ~v;
    @(negedge clk); engResultValid = 1;
    @(posedge clk); #1; engResultValid = 0;
    for (int m = 0; m < 4; m++) begin
      logic [255:0] e;
      busWrite(12'h00C, 32'(m) << 26);
      e = refSwap(v, m[0], m[1]);
      for (int i = 0; i < 8; i++) begin
        busRead(12'h0B0 + 12'(4*i), d);
        chk("R10 YO1 read view", d, e[i*32 +: 32]);
      end
    end
    busWrite(12'h00C, 32'h0);
  endtask

  task automatic t_robank();
    logic [31:0] d;
    logic [255:0] y2;
    y2 = ~engResY1;
    busWrite(12'h0F0, 32'hDEAD_BEEF);
    busRead(12'h0F0, d); chk("R11 YO2 ignores write", d, y2[31:0]);
    busWrite(12'h10C, 32'h1234_5678);
    busRead(12'h10C, d); chk("R11 YO2 top word", d, y2[255:224]);
    busWrite(12'h094, 32'h600D_F00D);
    busRead(12'h094, d); chk("R11 XO1 writable", d, 32'h600D_F00D);
  endtask

  task automatic t_misc();
    logic [31:0] d;
    engDebug = 32'h5AC3_1E7F;
    busRead(12'h200, d); chk("R12 debug", d, 32'h5AC3_1E7F);
    busRead(12'h004, d); chk("R12 hole 004", d, 0);
    busRead(12'h110, d); chk("R12 hole 110", d, 0);
    busRead(12'h1FC, d); chk("R12 hole 1FC", d, 0);
    busRead(12'h00E, d); chk("R12 misaligned", d, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rstN = 1;
    t_reset();
    t_init();
    t_pulses();
    t_busy();
    t_flags();
    t_priority();
    t_ctrl();
    t_inbank();
    t_outbank();
    t_robank();
    t_misc();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule